// File: doc/BRIEF.md
# Playback and Power Mode Controller

This block steps a music-playback device through its operating modes. It moves from the first supply and reset phases, through analog bring-up and initialisation, to an idle mode. From idle it goes to a standby mode once a score is queued, then to playback, and into and out of a low-power state for the digital core. Each clock the controller reads supply, reset and setup indications, the play-start bit, the digital power-down bit, a score-write strobe and the mute status of two volume paths. From these it picks the next mode. A request that is not allowed in the current mode is refused: the mode is held and an error pulse is raised.

The mode register is one-hot. The nine modes, as bit positions of `mode_o`, are: 0 DIG_RDY (waiting for digital supply), 1 HW_RST (hardware reset held), 2 ANA_RDY (waiting for analog supply), 3 ANA_PD (analog powered down), 4 INIT (initialised), 5 STOP (idle, score queue empty), 6 STBY (score queued, ready to play), 7 PLAY (playback running), 8 DPD (digital core powered down).

The transitions are: DIG_RDY to HW_RST, HW_RST to ANA_RDY, ANA_RDY to ANA_PD, ANA_PD to INIT or back to ANA_RDY, INIT to STOP or ANA_PD, STOP to STBY or DPD, STBY to PLAY or DPD, PLAY to STOP, and DPD to STOP. The core clock enable, the playback-run enable and the error flag are all registered. They change on the same edge as the mode.

Top module: `playpwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `mode_o` is 9'b000000001 (DIG_RDY), and `core_clk_en_o`, `play_run_o` and `err_o` are 0.
- R2: Bring-up runs one step per edge. DIG_RDY goes to HW_RST when `dig_pwr_ok_i` is 1. HW_RST goes to ANA_RDY when `hw_rst_i` is 0. ANA_RDY goes to ANA_PD when `ana_pwr_ok_i` is 1. ANA_PD goes to INIT when `init_done_i` is 1. Each mode is held while its condition is absent.
- R3: INIT goes to STOP when `setup_done_i` is 1. INIT goes to ANA_PD when `ana_pd_req_i` is 1 with both mutes at 1, and this path takes priority over `setup_done_i`. With `ana_pd_req_i` at 1 and either mute at 0, INIT is held and `err_o` pulses. ANA_PD goes to ANA_RDY when `ana_pwr_ok_i` is 0.
- R4: STOP goes to STBY when `fifo_wr_i` is 1 and `dp_i` is 0.
- R5: STBY goes to PLAY when `st_i` is 1. PLAY goes to STOP when `st_i` is 0 and `dp_i` is 0.
- R6: `dp_i` at 1 in STOP or STBY, with `hp_mute_i` and `fm_mute_i` both 1, goes to DPD.
- R7: `dp_i` at 1 in PLAY is refused. PLAY is held, even when `st_i` is 0, and `err_o` is 1 for each cycle the request is present.
- R8: `dp_i` at 1 in STOP or STBY while either mute is 0 is refused. The mode is held and `err_o` is 1.
- R9: DPD is left only when `dp_i` is 0, and it always goes to STOP, including when DPD was entered from STBY.
- R10: `core_clk_en_o` is 0 in DIG_RDY, HW_RST and DPD and 1 in every other mode, updating on the same edge as `mode_o`.
- R11: `play_run_o` is 1 exactly when `mode_o` is PLAY.
- R12: `mode_o` always has exactly one bit set, at the positions listed above.
- R13: In STOP and STBY, a `dp_i` request is evaluated ahead of `fifo_wr_i` and `st_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_pwr_ok_i | input | 1 | Digital supply is up |
| hw_rst_i | input | 1 | Hardware reset held |
| ana_pwr_ok_i | input | 1 | Analog supply is up |
| init_done_i | input | 1 | Analog-down initialisation finished |
| setup_done_i | input | 1 | Mute release and timbre setup finished |
| ana_pd_req_i | input | 1 | Request to return to analog power-down |
| fifo_wr_i | input | 1 | Score data written to queue |
| st_i | input | 1 | Play start (1) / stop (0) bit |
| dp_i | input | 1 | Digital power-down bit |
| hp_mute_i | input | 1 | Headphone volume is muted |
| fm_mute_i | input | 1 | FM volume is muted |
| mode_o | output | 9 | One-hot current mode |
| core_clk_en_o | output | 1 | Registered digital-core clock enable |
| play_run_o | output | 1 | Playback running |
| err_o | output | 1 | Illegal request refused this cycle |

## Verification
The hardest case to reach is leaving DPD after it was entered from STBY. Showing that the controller lands in STOP and not back in standby needs a full bring-up, a score write, then a muted power-down request and its release. The stimulus table walks the whole chain once, passes through STOP to DPD and back, then enters DPD again from STBY. On the way it offers every refused request: an unmuted analog-down, an unmuted digital-down, and a digital-down during playback. It also raises `dp_i` together with `fifo_wr_i` to show which request wins.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int NUM_MODES = 9;

    typedef enum logic [NUM_MODES-1:0] {
        M_DIG_RDY = 9'b000000001,
        M_HW_RST  = 9'b000000010,
        M_ANA_RDY = 9'b000000100,
        M_ANA_PD  = 9'b000001000,
        M_INIT    = 9'b000010000,
        M_STOP    = 9'b000100000,
        M_STBY    = 9'b001000000,
        M_PLAY    = 9'b010000000,
        M_DPD     = 9'b100000000
    } mode_e;

    typedef struct packed {
        logic dig_ok;
        logic hw_rst;
        logic ana_ok;
        logic init_done;
        logic setup_done;
        logic ana_pd_req;
        logic fifo_wr;
        logic st;
        logic dp;
        logic hp_mute;
        logic fm_mute;
    } ctrl_req_t;

endpackage

// File: rtl/pmc_next.sv
module pmc_next
    import pmc_pkg::*;
(
    input  mode_e     cur_i,
    input  ctrl_req_t req_i,
    output mode_e     nxt_o,
    output logic      refuse_o
);

    logic muted;
    assign muted = req_i.hp_mute && req_i.fm_mute;

    always_comb begin
        nxt_o    = cur_i;
        refuse_o = 1'b0;
        unique case (cur_i)
            M_DIG_RDY: if (req_i.dig_ok)  nxt_o = M_HW_RST;
            M_HW_RST:  if (!req_i.hw_rst) nxt_o = M_ANA_RDY;
            M_ANA_RDY: if (req_i.ana_ok)  nxt_o = M_ANA_PD;
            M_ANA_PD: begin
                if (!req_i.ana_ok)         nxt_o = M_ANA_RDY;
                else if (req_i.init_done)  nxt_o = M_INIT;
            end
            M_INIT: begin
                if (req_i.ana_pd_req) begin
                    if (muted) nxt_o    = M_ANA_PD;
                    else       refuse_o = 1'b1;
                end else if (req_i.setup_done) begin
                    nxt_o = M_STOP;
                end
            end
            M_STOP: begin
                if (req_i.dp) begin
                    if (muted) nxt_o    = M_DPD;
                    else       refuse_o = 1'b1;
                end else if (req_i.fifo_wr) begin
                    nxt_o = M_STBY;
                end
            end
            M_STBY: begin
                if (req_i.dp) begin
                    if (muted) nxt_o    = M_DPD;
                    else       refuse_o = 1'b1;
                end else if (req_i.st) begin
                    nxt_o = M_PLAY;
                end
            end
            M_PLAY: begin
                if (req_i.dp)       refuse_o = 1'b1;
                else if (!req_i.st) nxt_o    = M_STOP;
            end
            M_DPD: if (!req_i.dp) nxt_o = M_STOP;
            default: nxt_o = M_DIG_RDY;
        endcase
    end

endmodule

// File: rtl/pmc_outreg.sv
module pmc_outreg
    import pmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e nxt_i,
    input  logic  refuse_i,
    output logic  clk_en_o,
    output logic  run_o,
    output logic  err_o
);

    logic clk_en_d;
    logic run_d;

    always_comb begin
        clk_en_d = 1'b1;
        run_d    = 1'b0;
        unique case (nxt_i)
            M_DIG_RDY, M_HW_RST, M_DPD: clk_en_d = 1'b0;
            M_PLAY:                     run_d    = 1'b1;
            default:                    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en_o <= 1'b0;
            run_o    <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            clk_en_o <= clk_en_d;
            run_o    <= run_d;
            err_o    <= refuse_i;
        end
    end

    // R11
    run_not_with_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> clk_en_o);

endmodule

// File: rtl/playpwr_mode_ctrl.sv
module playpwr_mode_ctrl
    import pmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dig_pwr_ok_i,
    input  logic                 hw_rst_i,
    input  logic                 ana_pwr_ok_i,
    input  logic                 init_done_i,
    input  logic                 setup_done_i,
    input  logic                 ana_pd_req_i,
    input  logic                 fifo_wr_i,
    input  logic                 st_i,
    input  logic                 dp_i,
    input  logic                 hp_mute_i,
    input  logic                 fm_mute_i,
    output logic [NUM_MODES-1:0] mode_o,
    output logic                 core_clk_en_o,
    output logic                 play_run_o,
    output logic                 err_o
);

    mode_e     mode_q;
    mode_e     mode_d;
    logic      refuse;
    ctrl_req_t req;

    assign req = '{dig_ok:     dig_pwr_ok_i,
                   hw_rst:     hw_rst_i,
                   ana_ok:     ana_pwr_ok_i,
                   init_done:  init_done_i,
                   setup_done: setup_done_i,
                   ana_pd_req: ana_pd_req_i,
                   fifo_wr:    fifo_wr_i,
                   st:         st_i,
                   dp:         dp_i,
                   hp_mute:    hp_mute_i,
                   fm_mute:    fm_mute_i};

    pmc_next next_i (
        .cur_i    (mode_q),
        .req_i    (req),
        .nxt_o    (mode_d),
        .refuse_o (refuse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_DIG_RDY;
        else        mode_q <= mode_d;
    end

    pmc_outreg outs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_i    (mode_d),
        .refuse_i (refuse),
        .clk_en_o (core_clk_en_o),
        .run_o    (play_run_o),
        .err_o    (err_o)
    );

    assign mode_o = mode_q;

    // R12
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_o) == 1);

    // R7
    no_play_to_dpd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == M_PLAY |=> mode_q != M_DPD);

    // R9
    dpd_exit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_DPD && $past(mode_q) == M_DPD) |-> mode_q == M_STOP);

    // R6
    dpd_entry_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_DPD && $past(mode_q) != M_DPD) |-> $past(hp_mute_i && fm_mute_i));

    // R8
    err_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(mode_o));

    // R10
    gate_matches_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en_o == !(mode_q inside {M_DIG_RDY, M_HW_RST, M_DPD}));

endmodule

// File: tb/playpwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module playpwr_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [10:0] stim = 11'b11000000011;
    logic [8:0] mode_o;
    logic       core_clk_en_o, play_run_o, err_o;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    // stim bits: dig_ok hw_rst ana_ok init_done setup_done ana_pd_req fifo_wr st dp hp_mute fm_mute
    playpwr_mode_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dig_pwr_ok_i  (stim[10]),
        .hw_rst_i      (stim[9]),
        .ana_pwr_ok_i  (stim[8]),
        .init_done_i   (stim[7]),
        .setup_done_i  (stim[6]),
        .ana_pd_req_i  (stim[5]),
        .fifo_wr_i     (stim[4]),
        .st_i          (stim[3]),
        .dp_i          (stim[2]),
        .hp_mute_i     (stim[1]),
        .fm_mute_i     (stim[0]),
        .mode_o        (mode_o),
        .core_clk_en_o (core_clk_en_o),
        .play_run_o    (play_run_o),
        .err_o         (err_o)
    );

    // entry: {stimulus[10:0], expected mode bit index[3:0], expected err, requirement number[3:0]}
    localparam int NV = 24;
    localparam logic [19:0] VEC [NV] = '{
        {11'b11000000011, 4'd1, 1'b0, 4'd2},   // R2 DIG_RDY -> HW_RST
        {11'b11000000011, 4'd1, 1'b0, 4'd2},   // R2 hold in reset
        {11'b10000000011, 4'd2, 1'b0, 4'd2},   // R2 reset released
        {11'b10000000011, 4'd2, 1'b0, 4'd2},   // R2 wait analog supply
        {11'b10100000011, 4'd3, 1'b0, 4'd2},   // R2 -> ANA_PD
        {11'b10110000011, 4'd4, 1'b0, 4'd2},   // R2 -> INIT
        {11'b10100100011, 4'd3, 1'b0, 4'd3},   // R3 muted analog-down
        {11'b10000000011, 4'd2, 1'b0, 4'd3},   // R3 analog supply off
        {11'b10100000011, 4'd3, 1'b0, 4'd3},   // R3
        {11'b10110000011, 4'd4, 1'b0, 4'd3},   // R3
        {11'b10100100001, 4'd4, 1'b1, 4'd3},   // R3 unmuted analog-down refused
        {11'b10101000011, 4'd5, 1'b0, 4'd3},   // R3 -> STOP
        {11'b10100010111, 4'd8, 1'b0, 4'd13},  // R13 dp beats fifo write
        {11'b10100000011, 4'd5, 1'b0, 4'd9},   // R9 DPD -> STOP
        {11'b10100010011, 4'd6, 1'b0, 4'd4},   // R4 STOP -> STBY
        {11'b10100000110, 4'd6, 1'b1, 4'd8},   // R8 fm unmuted, refused
        {11'b10100000111, 4'd8, 1'b0, 4'd6},   // R6 STBY -> DPD
        {11'b10100000111, 4'd8, 1'b0, 4'd6},   // R6 held in DPD
        {11'b10100000011, 4'd5, 1'b0, 4'd9},   // R9 exit lands in STOP
        {11'b10100010011, 4'd6, 1'b0, 4'd4},   // R4
        {11'b10100001011, 4'd7, 1'b0, 4'd5},   // R5 STBY -> PLAY
        {11'b10100001111, 4'd7, 1'b1, 4'd7},   // R7 dp in PLAY refused
        {11'b10100001011, 4'd7, 1'b0, 4'd5},   // R5 stays in PLAY
        {11'b10100000011, 4'd5, 1'b0, 4'd5}    // R5 PLAY -> STOP
    };

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        chk({tag, " mode"}, mode_o, 9'b000000001);
        chk({tag, " clk_en"}, {8'd0, core_clk_en_o}, 9'd0);
        chk({tag, " run"}, {8'd0, play_run_o}, 9'd0);
        chk({tag, " err"}, {8'd0, err_o}, 9'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_reset_state("R1 in reset");
        rst_n = 1'b1;
        stim = 11'b00000000011;
        @(posedge clk); @(negedge clk);
        chk_reset_state("R1 after release");

        for (int v = 0; v < NV; v++) begin
            logic [8:0] exp_mode;
            logic       exp_en;
            string      tg;
            stim = VEC[v][19:9];
            @(posedge clk); @(negedge clk);
            exp_mode = 9'd1 << VEC[v][8:5];
            exp_en   = !(VEC[v][8:5] inside {4'd0, 4'd1, 4'd8});
            tg = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
            chk({tg, " mode"}, mode_o, exp_mode);
            chk({tg, " err"}, {8'd0, err_o}, {8'd0, VEC[v][4]});
            chk($sformatf("R10 vec%0d clk_en", v), {8'd0, core_clk_en_o}, {8'd0, exp_en});
            chk($sformatf("R11 vec%0d run", v), {8'd0, play_run_o}, {8'd0, VEC[v][8:5] == 4'd7});
        end

        // R12 encoding of STOP after the table
        chk("R12 STOP code", mode_o, 9'b000100000);

        // reset during playback: back to the initial state
        stim = 11'b10100010011;
        @(posedge clk); @(negedge clk);
        stim = 11'b10100001011;
        @(posedge clk); @(negedge clk);
        chk("R5 PLAY again", mode_o, 9'b010000000);
        rst_n = 1'b0;
        #1;
        chk_reset_state("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        stim = 11'b00000000011;
        @(posedge clk); @(negedge clk);
        chk("R2 hold without supply", mode_o, 9'b000000001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule